// File: doc/BRIEF.md
# Pipeline Exception Status Tracker

This block follows the exception status of every instruction in a five-stage in-order processor, one slot per pipeline register from decode to write-back. The fetch stage classifies each instruction as normal, bad address, illegal opcode or halt. Decode and execute carry that status forward. The memory stage can replace it with a bad-address code when the data access faults. The block acts on an exception only when the instruction holding it reaches write-back. In that cycle it pulses an exception-taken output, reports the faulting PC and status, and presents the handler address. At the following edge it turns every younger stage into a bubble.

The block also gates two side effects of younger instructions so that exceptions take effect in program order. The execute-stage condition-code update is blocked while an older instruction in memory or write-back is excepting. The data-memory store is blocked while write-back holds an exception or the storing instruction itself is faulting. The datapath, ALU and memories sit outside the block. The surrounding pipeline control supplies the stall and bubble requests.

Top module: `exc_pipe_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, every stage holds a bubble. `exc_taken` is 0, `exc_status` is 0, and both side-effect enables follow their request inputs.
- R2: Status codes are 0 normal, 1 bad address, 2 illegal opcode and 3 halt. Fetch gives bad address the highest priority, then illegal opcode, then halt, and otherwise normal.
- R3: Decode and execute pass status and PC through unchanged. An instruction presented at fetch in cycle c is reported at write-back in cycle c+4 when nothing stalls it, and not before.
- R4: `m_data_fault` replaces the status of the instruction in memory with bad address (1), including a status that was already non-normal. The instruction is reported one cycle later.
- R5: `exc_taken` is 1 exactly when write-back holds a non-normal status. In that cycle `exc_status` and `exc_pc` give that instruction's code and PC, and `redirect_pc` equals `HANDLER_PC`.
- R6: `cc_update_en` is 0 whenever the memory stage (including a data fault in the same cycle) or write-back holds a non-normal status. Otherwise it equals `e_sets_cc`.
- R7: `dmem_write_en` is 0 whenever write-back or the memory stage (including its own data fault) holds a non-normal status. Otherwise it equals `m_store_req`.
- R8: At the edge that ends an `exc_taken` cycle, decode, execute, memory and write-back all load bubbles. Younger excepting instructions and the fetch input of that cycle are never reported.
- R9: A bubble carries status normal. An instruction cancelled by `d_bubble` or `e_bubble` never raises its exception.
- R10: `d_stall` keeps the decode slot unchanged and drops the fetch input of that cycle. It delays the instruction's report by one cycle per stalled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_pc | input | PC_W | PC of the instruction at fetch |
| f_addr_fault | input | 1 | Fetch address is invalid |
| f_bad_opcode | input | 1 | Fetched opcode is illegal |
| f_halt | input | 1 | Fetched instruction is a halt |
| d_stall | input | 1 | Hold the decode slot |
| d_bubble | input | 1 | Load a bubble into decode |
| e_bubble | input | 1 | Load a bubble into execute |
| m_data_fault | input | 1 | Data address of the memory-stage instruction is invalid |
| e_sets_cc | input | 1 | Execute-stage instruction wants to update condition codes |
| m_store_req | input | 1 | Memory-stage instruction wants to write data memory |
| cc_update_en | output | 1 | Gated condition-code update |
| dmem_write_en | output | 1 | Gated data-memory write |
| exc_taken | output | 1 | Exception acted on this cycle |
| exc_status | output | 2 | Status code of the write-back instruction |
| exc_pc | output | PC_W | PC of the write-back instruction |
| redirect_pc | output | PC_W | Handler address to jump to |

## Verification
Two things can happen in the same cycle: an instruction with a memory-stage data fault can be headed for write-back while a younger instruction already carries an illegal-opcode status. The bench provokes this by feeding a normal instruction, then an illegal one, and asserting the data fault when the first reaches memory. It checks that condition codes are blocked in that cycle, that the first instruction's PC and bad-address code are reported, and that the younger fault is never reported in the cycles after the flush. The bench also makes a cancelling bubble fall in the same cycle as a stall, and checks that the held instruction reports exactly one cycle late.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    ST_AOK = 2'd0,
    ST_ADR = 2'd1,
    ST_INS = 2'd2,
    ST_HLT = 2'd3
  } exc_stat_e;

  localparam int NUM_SLOTS = 4;
  localparam int SLOT_D = 0;
  localparam int SLOT_E = 1;
  localparam int SLOT_M = 2;
  localparam int SLOT_W = 3;
endpackage

// File: rtl/exc_fetch_classify.sv
module exc_fetch_classify
  import exc_pkg::*;
(
  input  logic      addr_fault,
  input  logic      bad_opcode,
  input  logic      halt,
  output exc_stat_e status
);
  // Address fault first: opcode bytes are meaningless if unreadable.
  always_comb begin
    if (addr_fault)      status = ST_ADR;
    else if (bad_opcode) status = ST_INS;
    else if (halt)       status = ST_HLT;
    else                 status = ST_AOK;
  end
endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            hold,
  input  exc_stat_e       st_in,
  input  logic [PC_W-1:0] pc_in,
  output exc_stat_e       st_q,
  output logic [PC_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st_q <= ST_AOK;
      pc_q <= '0;
    end else if (!hold) begin
      st_q <= st_in;
      pc_q <= pc_in;
    end
  end
endmodule

// File: rtl/exc_side_gate.sv
module exc_side_gate
  import exc_pkg::*;
(
  input  exc_stat_e m_st_eff,
  input  exc_stat_e w_st,
  input  logic      cc_req,
  input  logic      store_req,
  output logic      cc_en,
  output logic      store_en
);
  logic older_bad;
  assign older_bad = (m_st_eff != ST_AOK) || (w_st != ST_AOK);
  assign cc_en     = cc_req && !older_bad;
  assign store_en  = store_req && !older_bad;
endmodule

// File: rtl/exc_pipe_tracker.sv
module exc_pipe_tracker
  import exc_pkg::*;
#(
  parameter int              PC_W       = 16,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] f_pc,
  input  logic            f_addr_fault,
  input  logic            f_bad_opcode,
  input  logic            f_halt,
  input  logic            d_stall,
  input  logic            d_bubble,
  input  logic            e_bubble,
  input  logic            m_data_fault,
  input  logic            e_sets_cc,
  input  logic            m_store_req,
  output logic            cc_update_en,
  output logic            dmem_write_en,
  output logic            exc_taken,
  output logic [1:0]      exc_status,
  output logic [PC_W-1:0] exc_pc,
  output logic [PC_W-1:0] redirect_pc
);
  exc_stat_e       f_st;
  exc_stat_e       m_eff;
  exc_stat_e       st_d [NUM_SLOTS];
  exc_stat_e       st_q [NUM_SLOTS];
  logic [PC_W-1:0] pc_d [NUM_SLOTS];
  logic [PC_W-1:0] pc_q [NUM_SLOTS];
  logic            clr  [NUM_SLOTS];
  logic            hld  [NUM_SLOTS];
  logic            flush;

  exc_fetch_classify u_cls (
    .addr_fault (f_addr_fault),
    .bad_opcode (f_bad_opcode),
    .halt       (f_halt),
    .status     (f_st)
  );

  // Memory stage may overwrite with a data-address fault.
  assign m_eff = m_data_fault ? ST_ADR : st_q[SLOT_M];
  assign flush = (st_q[SLOT_W] != ST_AOK);

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      hld[i] = 1'b0;
      clr[i] = flush;
      if (i == SLOT_D) begin
        st_d[i] = f_st;
        pc_d[i] = f_pc;
      end else if (i == SLOT_W) begin
        st_d[i] = m_eff;
        pc_d[i] = pc_q[i-1];
      end else begin
        st_d[i] = st_q[i-1];
        pc_d[i] = pc_q[i-1];
      end
    end
    hld[SLOT_D] = d_stall;
    clr[SLOT_D] = flush || d_bubble;
    clr[SLOT_E] = flush || e_bubble;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    exc_stage_reg #(.PC_W(PC_W)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .clear (clr[g]),
      .hold  (hld[g]),
      .st_in (st_d[g]),
      .pc_in (pc_d[g]),
      .st_q  (st_q[g]),
      .pc_q  (pc_q[g])
    );
  end

  exc_side_gate u_gate (
    .m_st_eff  (m_eff),
    .w_st      (st_q[SLOT_W]),
    .cc_req    (e_sets_cc),
    .store_req (m_store_req),
    .cc_en     (cc_update_en),
    .store_en  (dmem_write_en)
  );

  assign exc_taken   = flush;
  assign exc_status  = st_q[SLOT_W];
  assign exc_pc      = pc_q[SLOT_W];
  assign redirect_pc = HANDLER_PC;
endmodule

// File: rtl/exc_pipe_tracker_chk.sv
module exc_pipe_tracker_chk
  import exc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       f_addr_fault,
  input logic       d_stall,
  input logic       d_bubble,
  input logic       e_bubble,
  input logic       m_data_fault,
  input logic       cc_update_en,
  input logic       dmem_write_en,
  input logic       exc_taken,
  input logic [1:0] exc_status,
  input exc_stat_e  d_st,
  input exc_stat_e  e_st,
  input exc_stat_e  m_st
);
  p_fetch_adr_r2: assert property (@(posedge clk) disable iff (rst)
    (f_addr_fault && !exc_taken && !d_stall && !d_bubble) |=> d_st == ST_ADR);

  p_pass_de_r3: assert property (@(posedge clk) disable iff (rst)
    (!exc_taken && !e_bubble) |=> e_st == $past(d_st));

  p_mem_adr_r4: assert property (@(posedge clk) disable iff (rst)
    (m_data_fault && !exc_taken) |=> (exc_taken && exc_status == ST_ADR));

  p_cc_block_r6: assert property (@(posedge clk) disable iff (rst)
    m_data_fault |-> !cc_update_en);

  p_store_block_r7: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> !dmem_write_en);

  p_flush_r8: assert property (@(posedge clk) disable iff (rst)
    exc_taken |=> (!exc_taken && d_st == ST_AOK && e_st == ST_AOK && m_st == ST_AOK));

  p_bubble_aok_r9: assert property (@(posedge clk) disable iff (rst)
    (e_bubble && !exc_taken) |=> e_st == ST_AOK);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (d_stall && !d_bubble && !exc_taken) |=> d_st == $past(d_st));
endmodule

bind exc_pipe_tracker exc_pipe_tracker_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .f_addr_fault  (f_addr_fault),
  .d_stall       (d_stall),
  .d_bubble      (d_bubble),
  .e_bubble      (e_bubble),
  .m_data_fault  (m_data_fault),
  .cc_update_en  (cc_update_en),
  .dmem_write_en (dmem_write_en),
  .exc_taken     (exc_taken),
  .exc_status    (exc_status),
  .d_st          (st_q[0]),
  .e_st          (st_q[1]),
  .m_st          (st_q[2])
);

// File: tb/exc_pipe_tracker_test.sv
`timescale 1ns/1ps
module exc_pipe_tracker_test;
  localparam int              PC_W = 16;
  localparam logic [PC_W-1:0] HPC  = 16'h0100;

  logic            clk = 1'b0;
  logic            rst;
  logic [PC_W-1:0] f_pc;
  logic            f_addr_fault, f_bad_opcode, f_halt;
  logic            d_stall, d_bubble, e_bubble, m_data_fault;
  logic            e_sets_cc, m_store_req;
  logic            cc_update_en, dmem_write_en, exc_taken;
  logic [1:0]      exc_status;
  logic [PC_W-1:0] exc_pc, redirect_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  exc_pipe_tracker #(.PC_W(PC_W), .HANDLER_PC(HPC)) uut (
    .clk(clk), .rst(rst), .f_pc(f_pc),
    .f_addr_fault(f_addr_fault), .f_bad_opcode(f_bad_opcode), .f_halt(f_halt),
    .d_stall(d_stall), .d_bubble(d_bubble), .e_bubble(e_bubble),
    .m_data_fault(m_data_fault), .e_sets_cc(e_sets_cc), .m_store_req(m_store_req),
    .cc_update_en(cc_update_en), .dmem_write_en(dmem_write_en),
    .exc_taken(exc_taken), .exc_status(exc_status),
    .exc_pc(exc_pc), .redirect_pc(redirect_pc)
  );

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put_f(input logic [PC_W-1:0] pc, input logic a, input logic i, input logic h);
    f_pc = pc; f_addr_fault = a; f_bad_opcode = i; f_halt = h;
  endtask

  task automatic expect_exc(input string req, input logic tk, input logic [1:0] st, input logic [PC_W-1:0] pc);
    chk({req, " exc_taken"}, 32'(exc_taken), 32'(tk));
    if (tk) begin
      chk({req, " exc_status"}, 32'(exc_status), 32'(st));
      chk({req, " exc_pc"}, 32'(exc_pc), 32'(pc));
      chk({req, " redirect_pc"}, 32'(redirect_pc), 32'(HPC));
    end
  endtask

  function automatic logic [1:0] exp_code(input logic a, input logic i, input logic h);
    return a ? 2'd1 : (i ? 2'd2 : (h ? 2'd3 : 2'd0));
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    put_f('0, 0, 0, 0);
    d_stall = 0; d_bubble = 0; e_bubble = 0; m_data_fault = 0;
    e_sets_cc = 1; m_store_req = 1;
    repeat (3) cyc;
    #1;
    // R1: state during reset
    chk("R1 exc_taken in reset", 32'(exc_taken), 0);
    rst = 1'b0;
    #1;
    chk("R1 exc_taken", 32'(exc_taken), 0);
    chk("R1 exc_status", 32'(exc_status), 0);
    chk("R1 cc_update_en", 32'(cc_update_en), 1);
    chk("R1 dmem_write_en", 32'(dmem_write_en), 1);

    // R2/R3/R5/R6/R7/R8: sweep of all fetch fault combinations
    for (int k = 0; k < 8; k++) begin
      logic [1:0] ec;
      ec = exp_code(k[0], k[1], k[2]);
      put_f(16'h0040 + 16'(k), k[0], k[1], k[2]);
      cyc;                                  // P1: in decode
      put_f(16'h0007, 0, 0, 0);
      cyc;                                  // P2: execute
      cyc;                                  // P3: memory
      #1;
      chk("R3 not reported early", 32'(exc_taken), 0);
      chk("R6 cc blocked by memory stage", 32'(cc_update_en), 32'(ec == 2'd0));
      cyc;                                  // P4: write-back
      #1;
      expect_exc("R2 R5 sweep", ec != 2'd0, ec, 16'h0040 + 16'(k));
      chk("R7 store blocked by write-back", 32'(dmem_write_en), 32'(ec == 2'd0));
      chk("R6 cc blocked by write-back", 32'(cc_update_en), 32'(ec == 2'd0));
      cyc;
      #1;
      chk("R8 single pulse", 32'(exc_taken), 0);
    end
    repeat (4) cyc;

    // R4: data fault overwrites an illegal-opcode status
    put_f(16'h0050, 0, 1, 0);
    cyc; put_f(16'h0007, 0, 0, 0);
    cyc; cyc;                               // P3: in memory
    m_data_fault = 1;
    #1;
    chk("R6 cc blocked by same-cycle data fault", 32'(cc_update_en), 0);
    chk("R7 store blocked by own data fault", 32'(dmem_write_en), 0);
    cyc; m_data_fault = 0;
    #1;
    expect_exc("R4 overwrite to ADR", 1, 2'd1, 16'h0050);
    repeat (4) cyc;

    // R8: older data fault plus younger illegal opcode, halt fetched in exc cycle
    put_f(16'h0010, 0, 0, 0);
    cyc; put_f(16'h0011, 0, 1, 0);          // younger illegal
    cyc; put_f(16'h0012, 0, 0, 0);
    cyc;                                    // P3: older in memory
    m_data_fault = 1;
    #1;
    chk("R6 cc blocked same cycle as younger fault", 32'(cc_update_en), 0);
    cyc; m_data_fault = 0;
    put_f(16'h0013, 0, 0, 1);               // halt fetched during exc cycle
    #1;
    expect_exc("R4 R8 older reported", 1, 2'd1, 16'h0010);
    cyc; put_f(16'h0014, 0, 0, 0);
    for (int n = 0; n < 5; n++) begin
      #1;
      chk("R8 younger never reported", 32'(exc_taken), 0);
      cyc;
    end

    // R9: cancellation by bubbles on a mispredicted path
    put_f(16'h0020, 0, 1, 0);
    cyc;                                    // P1: illegal in decode
    put_f(16'h0021, 1, 0, 0);
    e_bubble = 1; d_bubble = 1;
    cyc; e_bubble = 0; d_bubble = 0;
    put_f(16'h0022, 0, 0, 0);
    for (int n = 0; n < 5; n++) begin
      #1;
      chk("R9 cancelled never reported", 32'(exc_taken), 0);
      chk("R9 cc not blocked by bubbles", 32'(cc_update_en), 1);
      cyc;
    end

    // R10: stall with execute bubble delays report by one cycle
    put_f(16'h0030, 0, 0, 1);
    cyc;                                    // P1: halt in decode
    put_f(16'h0031, 0, 1, 0);
    d_stall = 1; e_bubble = 1;
    cyc; d_stall = 0; e_bubble = 0;         // P2: decode held
    put_f(16'h0032, 0, 0, 0);
    cyc; cyc;                               // P4
    #1;
    chk("R10 not reported at unstalled time", 32'(exc_taken), 0);
    cyc;                                    // P5
    #1;
    expect_exc("R10 halt reported one cycle late", 1, 2'd3, 16'h0030);
    cyc;
    #1;
    chk("R10 R8 dropped fetch not reported", 32'(exc_taken), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule